// File: doc/BRIEF.md
# Triggered Signal Capture Buffer

This block is an on-chip debug capture engine. While armed it stores one sample of a group of probed signals on every edge of its sample clock into a ring memory of parameterised depth. Once the memory is full, each new sample overwrites the oldest one. Each stored sample is also tested against a mask-and-compare trigger. After the trigger hits, a programmed number of further samples is stored and then capture freezes. The memory therefore holds a window of history from before the trigger and after it.

A host arms the engine with a one-cycle pulse, waits for the done flag, and then reads the frozen window through a logical read index, where index 0 is the oldest valid sample. A count of valid entries stops the host from reading slots that were never written since the engine was armed. A trigger index output tells the host where the trigger sample sits inside the window. Re-arming clears the flag and the count but leaves the memory contents alone. The depth must be a power of two.

Top module: `sigtrap_capture`

## Requirements
- R1: After reset, armed_o and done_o are 0 and valid_count_o is 0.
- R2: A high arm_i at a clock edge stores no sample. From the next cycle armed_o is 1, done_o is 0 and valid_count_o is 0. This also holds when the engine was already armed or done.
- R3: On each edge while armed_o is 1, probe_i is stored and valid_count_o rises by one, saturating at DEPTH.
- R4: A sample hits the trigger when (probe_i & trig_mask_i) == (trig_value_i & trig_mask_i); a mask bit of 1 means the bit is compared, so an all-zero mask hits on any sample. A hit has no effect while armed_o is 0.
- R5: After the trigger sample, exactly post_count_i further samples are stored. On the edge that stores the last of them, armed_o falls and done_o rises. With post_count_i = 0, the trigger sample is the last one stored.
- R6: While done_o is 1 and arm_i is low, no sample is stored and valid_count_o, trig_idx_o and the memory contents stay unchanged.
- R7: rd_data_o shows, one cycle after rd_addr_i is presented, the sample at logical index rd_addr_i. Index 0 is the first sample stored after arming while fewer than DEPTH samples are held, and otherwise the oldest of the last DEPTH samples.
- R8: When done_o is 1, trig_idx_o equals valid_count_o - 1 - the post-trigger count latched at the trigger.
- R9: Hits on samples stored after the trigger are ignored and do not restart the post-trigger count.
- R10: post_count_i is latched at the trigger sample; later changes to it do not alter the capture window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | One-cycle pulse that starts a new capture |
| probe_i | input | PROBE_W | Probed signals |
| trig_mask_i | input | PROBE_W | Trigger compare mask, 1 = bit compared |
| trig_value_i | input | PROBE_W | Trigger compare value |
| post_count_i | input | AW | Samples stored after the trigger sample |
| rd_addr_i | input | AW | Logical read index, 0 = oldest |
| armed_o | output | 1 | Engine is storing samples |
| done_o | output | 1 | Capture frozen |
| valid_count_o | output | AW+1 | Number of valid stored samples |
| trig_idx_o | output | AW | Logical index of the trigger sample |
| rd_data_o | output | PROBE_W | Read data, one cycle after rd_addr_i |

## Verification
The bench drives a probe value half a cycle before the edge that stores it. armed_o, done_o, valid_count_o and trig_idx_o change at that same edge, so the bench samples them on the following falling edge. Readout takes one more register, so the bench issues each read index on a falling edge and checks rd_data_o just after the next rising edge. A reference ring model in the bench supplies the expected values and is fed through a scoreboard queue. The tests cover a capture without wrap and one after many wraps, a zero post-trigger count, the largest post-trigger count, hits that arrive during the post-trigger phase or while the engine is idle, and re-arming in the middle of a capture.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_WAIT = 2'd1,
        CAP_POST = 2'd2,
        CAP_DONE = 2'd3
    } cap_state_e;
endpackage

// File: rtl/cap_trig_match.sv
module cap_trig_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] probe,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] value,
    output logic         hit
);
    logic [W-1:0] bit_ok;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign bit_ok[i] = ~mask[i] | (probe[i] ~^ value[i]);
        end
    endgenerate

    assign hit = &bit_ok;
endmodule

// File: rtl/cap_ring_mem.sv
module cap_ring_mem #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          hit,
    input  logic [AW-1:0] post_len,
    output logic          we,
    output logic [AW-1:0] wptr,
    output cap_state_e    state,
    output logic [AW:0]   fill,
    output logic [AW-1:0] trig_ptr
);
    localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

    typedef struct packed {
        cap_state_e    state;
        logic [AW-1:0] wptr;
        logic [AW:0]   fill;
        logic [AW-1:0] rem;
        logic [AW-1:0] trig_ptr;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  we_d;

    always_comb begin
        c_d  = c_q;
        we_d = 1'b0;
        if (arm) begin
            c_d.state = CAP_WAIT;
            c_d.wptr  = '0;
            c_d.fill  = '0;
            c_d.rem   = '0;
        end else if (c_q.state == CAP_WAIT || c_q.state == CAP_POST) begin
            we_d      = 1'b1;
            c_d.wptr  = c_q.wptr + 1'b1;
            c_d.fill  = (c_q.fill == FULL) ? c_q.fill : c_q.fill + 1'b1;
            if (c_q.state == CAP_WAIT) begin
                if (hit) begin
                    c_d.trig_ptr = c_q.wptr;
                    c_d.rem      = post_len;
                    c_d.state    = (post_len == '0) ? CAP_DONE : CAP_POST;
                end
            end else begin
                c_d.rem = c_q.rem - 1'b1;
                if (c_q.rem == AW'(1)) begin
                    c_d.state = CAP_DONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{state: CAP_IDLE, wptr: '0, fill: '0, rem: '0, trig_ptr: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign we       = we_d;
    assign wptr     = c_q.wptr;
    assign state    = c_q.state;
    assign fill     = c_q.fill;
    assign trig_ptr = c_q.trig_ptr;

    // R2
    arm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (c_q.state == CAP_WAIT && c_q.fill == '0));

    // R3
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.fill <= FULL);

    // R5
    zero_post_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == CAP_WAIT && hit && !arm && post_len == '0) |=> c_q.state == CAP_DONE);

    // R6
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == CAP_DONE && !arm) |=>
            (c_q.state == CAP_DONE && $stable(c_q.wptr) && $stable(c_q.fill) && $stable(c_q.trig_ptr)));

    // R9
    post_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == CAP_POST && !arm && c_q.rem > AW'(1)) |=>
            (c_q.state == CAP_POST && c_q.rem == $past(c_q.rem) - 1'b1));
endmodule

// File: rtl/sigtrap_capture.sv
module sigtrap_capture
    import cap_pkg::*;
#(
    parameter int PROBE_W = 8,
    parameter int DEPTH   = 16,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm_i,
    input  logic [PROBE_W-1:0] probe_i,
    input  logic [PROBE_W-1:0] trig_mask_i,
    input  logic [PROBE_W-1:0] trig_value_i,
    input  logic [AW-1:0]      post_count_i,
    input  logic [AW-1:0]      rd_addr_i,
    output logic               armed_o,
    output logic               done_o,
    output logic [AW:0]        valid_count_o,
    output logic [AW-1:0]      trig_idx_o,
    output logic [PROBE_W-1:0] rd_data_o
);
    logic          hit;
    logic          we;
    logic [AW-1:0] wptr;
    logic [AW:0]   fill;
    logic [AW-1:0] trig_ptr;
    logic [AW-1:0] oldest;
    logic [AW-1:0] rd_phys;
    cap_state_e    state;

    cap_trig_match #(.W(PROBE_W)) u_match (
        .probe (probe_i),
        .mask  (trig_mask_i),
        .value (trig_value_i),
        .hit   (hit)
    );

    cap_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm_i),
        .hit      (hit),
        .post_len (post_count_i),
        .we       (we),
        .wptr     (wptr),
        .state    (state),
        .fill     (fill),
        .trig_ptr (trig_ptr)
    );

    // Oldest valid slot: slot 0 until the ring wraps, then the next write slot.
    assign oldest  = (fill == (AW+1)'(DEPTH)) ? wptr : '0;
    assign rd_phys = oldest + rd_addr_i;

    cap_ring_mem #(.W(PROBE_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (wptr),
        .wdata (probe_i),
        .raddr (rd_phys),
        .rdata (rd_data_o)
    );

    assign armed_o       = (state == CAP_WAIT) || (state == CAP_POST);
    assign done_o        = (state == CAP_DONE);
    assign valid_count_o = fill;
    assign trig_idx_o    = trig_ptr - oldest;

    // R1
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed_o && done_o));

    // R4
    idle_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_o && !arm_i) |=> $stable(valid_count_o));
endmodule

// File: tb/sigtrap_capture_tb.sv
module sigtrap_capture_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int D  = 16;
    localparam int AW = $clog2(D);

    logic          clk = 0;
    logic          rst_n = 0;
    logic          arm_i = 0;
    logic [W-1:0]  probe_i = '0;
    logic [W-1:0]  mask_i = '0;
    logic [W-1:0]  value_i = '0;
    logic [AW-1:0] post_i = '0;
    logic [AW-1:0] rd_addr_i = '0;
    logic          armed_o, done_o;
    logic [AW:0]   count_o;
    logic [AW-1:0] tidx_o;
    logic [W-1:0]  rd_data_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    sigtrap_capture #(.PROBE_W(W), .DEPTH(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .probe_i(probe_i),
        .trig_mask_i(mask_i), .trig_value_i(value_i), .post_count_i(post_i),
        .rd_addr_i(rd_addr_i), .armed_o(armed_o), .done_o(done_o),
        .valid_count_o(count_o), .trig_idx_o(tidx_o), .rd_data_o(rd_data_o)
    );

    int n_chk = 0, n_bad = 0;

    // reference model: 0 idle, 1 waiting, 2 post, 3 done
    int           m_state = 0, m_rem = 0, m_post = 0;
    logic [W-1:0] hist[$];

    // scoreboard for readout
    logic [W-1:0] exp_q[$];
    logic         rd_issue = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_status(string tag);
        chk({tag, " armed"}, int'(armed_o), int'(m_state == 1 || m_state == 2));
        chk({tag, " done"},  int'(done_o),  int'(m_state == 3));
        chk({tag, " count"}, int'(count_o), hist.size());
        if (m_state == 3)
            chk({tag, " R8 trig_idx"}, int'(tidx_o), hist.size() - 1 - m_post);
    endtask

    task automatic tick(logic [W-1:0] v);
        probe_i = v;
        @(posedge clk);
        if (m_state == 1 || m_state == 2) begin
            hist.push_back(v);
            if (hist.size() > D) void'(hist.pop_front());
            if (m_state == 1) begin
                if ((v & mask_i) == (value_i & mask_i)) begin
                    m_post = int'(post_i);
                    m_rem  = m_post;
                    m_state = (m_post == 0) ? 3 : 2;
                end
            end else begin
                m_rem--;
                if (m_rem == 0) m_state = 3;
            end
        end
        @(negedge clk);
    endtask

    task automatic do_arm();
        arm_i = 1;
        @(posedge clk);
        m_state = 1;
        hist.delete();
        @(negedge clk);
        arm_i = 0;
    endtask

    task automatic read_all();
        for (int i = 0; i < hist.size(); i++) begin
            rd_addr_i = AW'(i);
            exp_q.push_back(hist[i]);
            rd_issue = 1;
            @(negedge clk);
        end
        rd_issue = 0;
        @(negedge clk);
    endtask

    // monitor: data is due one edge after the index was presented (R7)
    always @(posedge clk) begin
        if (rd_issue) begin
            #1;
            if (exp_q.size() == 0) chk("R7 readout underflow", 1, 0);
            else chk("R7 readout", int'(rd_data_o), int'(exp_q.pop_front()));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R3 watchdog act=hung exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_status("R1 reset");
        rst_n = 1;
        @(negedge clk);
        chk_status("R1 after release");

        // R4: all-zero mask would hit, but engine is idle
        mask_i = '0;
        for (int i = 0; i < 3; i++) tick(W'(i));
        chk_status("R4 idle ignore");

        // R2: re-arm mid capture clears count
        mask_i = 8'hFF; value_i = 8'hFF; post_i = 2;
        do_arm();
        chk_status("R2 arm");
        for (int i = 0; i < 4; i++) tick(W'(i));
        chk_status("R3 partial");
        do_arm();
        chk_status("R2 rearm");

        // R5 R9 R10: no-wrap capture, post=3
        mask_i = 8'hF0; value_i = 8'hA0; post_i = 3;
        do_arm();
        for (int i = 1; i <= 5; i++) tick(W'(i));
        tick(8'hA7);
        chk_status("R5 trigger seen");
        tick(8'h11);
        post_i = 7;
        tick(8'hA0);
        chk_status("R9 R10 post phase");
        tick(8'h13);
        chk_status("R5 done post3");
        chk("R8 idx value", int'(tidx_o), 5);
        for (int i = 0; i < 3; i++) tick(8'hA0);
        chk_status("R6 frozen");
        read_all();

        // R3 R7: wrapped capture, post=4
        mask_i = 8'hFF; value_i = 8'h80; post_i = 4;
        do_arm();
        for (int i = 0; i < 30; i++) tick(W'(8'h40 + i));
        chk_status("R3 saturate");
        tick(8'h80);
        for (int i = 0; i < 4; i++) tick(W'(8'h20 + i));
        chk_status("R5 done wrapped");
        chk("R8 idx wrapped", int'(tidx_o), 11);
        read_all();

        // R4 R5: zero mask hits first sample, post=0
        mask_i = '0; post_i = 0;
        do_arm();
        tick(8'h5A);
        chk_status("R5 post0");
        chk("R8 idx post0", int'(tidx_o), 0);
        read_all();

        // R5: largest post count, trigger lands at index 0
        mask_i = 8'h0F; value_i = 8'h05; post_i = AW'(D - 1);
        do_arm();
        tick(8'h10); tick(8'h20); tick(8'h30);
        tick(8'h15);
        for (int i = 0; i < D - 1; i++) tick(W'(8'h60 + i));
        chk_status("R5 max post");
        chk("R8 idx max post", int'(tidx_o), 0);
        read_all();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule